// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Register Access

This block gives a processor word-wide access to the five national spare bits of an E1 link. In the E1 frame these bits are the last five bit slots of time slot 0 in the frames that do not carry the alignment word. On the receive side, the block follows a frame-aligned bit stream using a frame strobe and a multiframe strobe. It gathers one spare bit per service word for each of the five bit slots, which gives eight bits per slot across a sixteen-frame CRC multiframe. At every multiframe boundary it copies the gathered bytes into five read-only registers and raises a receive interrupt.

On the transmit side, software writes five registers. At each transmit multiframe boundary their contents move into shadow registers, a transmit interrupt asks for fresh data, and the shadow bytes go out bit by bit in the service words of the multiframe that has just started. If software writes nothing new, the same bytes are sent again. A time-slot-0 transparent input turns insertion off completely.

Both interrupts are sticky and cleared by writing 1. Each has its own enable bit. All registers sit on a simple single-cycle bus with a combinational read.

Top module: `sa_bit_access`

## Requirements
- R1: Frames are numbered 0 to 15 from the multiframe strobe. Bits within a frame are numbered from 0, where bit 0 is the bit that carries the frame strobe. Spare-bit slots are bits 3 to 7 of the odd frames. Bit 3 carries spare bit 4 and bit 7 carries spare bit 8. No other bit position is treated as a spare bit on receive or on transmit.
- R2: Receive registers are at addresses 0x0 to 0x4, one per spare bit 4 to 8. In each register, bit 7 holds the bit from frame 1 and bit 0 holds the bit from frame 15.
- R3: The first multiframe strobe after reset only aligns the block: it loads nothing and raises no interrupt. Every later receive multiframe strobe loads the bits of the multiframe that just ended. Between strobes the receive registers do not change.
- R4: Receive inputs sampled while the receive bit enable is low are ignored. This includes both strobes.
- R5: Transmit registers are at addresses 0x8 to 0xC and read back what was written. At each transmit multiframe strobe they are copied to shadow storage. The shadow bytes are sent in that multiframe's spare-bit slots, using the bit order of R2.
- R6: If no new value is written, the shadow bytes are sent again unchanged in the next multiframe.
- R7: A transmit register write in the same cycle as the shadow copy does not reach the current multiframe. It is sent starting from the following multiframe.
- R8: While the transparent input is high, `tx_sa_ins` stays low and `tx_data_out` equals `tx_data_in`. Outside spare-bit slots the output always equals `tx_data_in`.
- R9: The status register at 0xE has bit 0 set by a receive load and bit 1 set by a transmit shadow copy. Both bits are sticky, and writing 1 to a bit clears only that bit.
- R10: The mask register at 0xF enables `irq_rx` with bit 0 and `irq_tx` with bit 1. After reset every register reads 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit_en | input | 1 | Receive bit valid this cycle |
| rx_frm_start | input | 1 | Receive bit is bit 0 of a frame |
| rx_mf_start | input | 1 | Receive bit is bit 0 of frame 0 |
| rx_data | input | 1 | Receive line bit |
| tx_bit_en | input | 1 | Transmit bit slot this cycle |
| tx_frm_start | input | 1 | Transmit bit is bit 0 of a frame |
| tx_mf_start | input | 1 | Transmit bit is bit 0 of frame 0 |
| tx_data_in | input | 1 | Transmit bit before insertion |
| ts0_transparent | input | 1 | Disables spare-bit insertion |
| tx_data_out | output | 1 | Transmit bit after insertion |
| tx_sa_ins | output | 1 | High when this bit was replaced |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_rx | output | 1 | Masked receive multiframe interrupt |
| irq_tx | output | 1 | Masked transmit multiframe interrupt |

## Verification
The bench checks byte patterns whose only set bit is at one edge of the register. A design that reversed the service-word order or shifted the slot window by one bit would put those bits in the wrong register position, or in the wrong register. It also sends a strobe before alignment: a design that loaded on that strobe would raise a receive interrupt with junk data. Idle cycles are inserted that carry strobes and inverted data, to catch a design that acts without the bit enable. A register write is placed in the same cycle as the shadow copy: a design that let it through would change the multiframe already in progress instead of the next one. The bench also checks selective write-1-to-clear and insertion while transparent.

// File: rtl/sa_pkg.sv
package sa_pkg;
    localparam int unsigned RX_BASE   = 0;
    localparam int unsigned TX_BASE   = 8;
    localparam int unsigned STAT_ADDR = 14;
    localparam int unsigned MASK_ADDR = 15;

    typedef struct packed {
        logic tx;
        logic rx;
    } irq_pair_t;
endpackage

// File: rtl/sa_slot_tracker.sv
module sa_slot_tracker #(
    parameter  int FRAME_BITS = 256,
    parameter  int MF_FRAMES  = 16,
    parameter  int SA_COUNT   = 5,
    parameter  int SA_FIRST   = 3,
    localparam int BW  = $clog2(FRAME_BITS),
    localparam int FW  = $clog2(MF_FRAMES),
    localparam int SAW = $clog2(SA_COUNT),
    localparam int SWW = FW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  logic           frm_start,
    input  logic           mf_start,
    output logic           slot_hit,
    output logic [SAW-1:0] sa_sel,
    output logic [SWW-1:0] sw_sel,
    output logic           mf_begin
);
    typedef struct packed {
        logic [BW-1:0] bitpos;
        logic [FW-1:0] frm;
        logic          aligned;
    } trk_t;

    trk_t          st_d, st_q;
    logic [BW-1:0] cur_bit;
    logic [BW-1:0] rel_bit;
    logic [FW-1:0] cur_frm;
    logic          aligned_now;
    logic          in_window;

    always_comb begin
        st_d = st_q;
        // position of the bit presented this cycle
        if (frm_start)
            cur_bit = '0;
        else if (st_q.bitpos == BW'(FRAME_BITS - 1))
            cur_bit = st_q.bitpos;
        else
            cur_bit = st_q.bitpos + 1'b1;

        if (mf_start)
            cur_frm = '0;
        else if (frm_start)
            cur_frm = st_q.frm + 1'b1;
        else
            cur_frm = st_q.frm;

        aligned_now = st_q.aligned | mf_start;
        rel_bit     = cur_bit - BW'(SA_FIRST);
        in_window   = (cur_bit >= BW'(SA_FIRST)) && (rel_bit < BW'(SA_COUNT));

        // odd frames carry the service word
        slot_hit = bit_en & aligned_now & cur_frm[0] & in_window;
        sa_sel   = rel_bit[SAW-1:0];
        sw_sel   = cur_frm[FW-1:1];
        mf_begin = bit_en & mf_start;

        if (bit_en) begin
            st_d.bitpos  = cur_bit;
            st_d.frm     = cur_frm;
            st_d.aligned = aligned_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bitpos  <= BW'(FRAME_BITS - 1);
            st_q.frm     <= '0;
            st_q.aligned <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sa_rx_collect.sv
module sa_rx_collect #(
    parameter  int SA_COUNT  = 5,
    parameter  int SW_PER_MF = 8,
    localparam int SAW = $clog2(SA_COUNT),
    localparam int SWW = $clog2(SW_PER_MF)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   slot_hit,
    input  logic [SAW-1:0]                         sa_sel,
    input  logic [SWW-1:0]                         sw_sel,
    input  logic                                   bit_in,
    input  logic                                   mf_begin,
    output logic [SA_COUNT-1:0][SW_PER_MF-1:0]     snap,
    output logic                                   load
);
    typedef struct packed {
        logic [SA_COUNT-1:0][SW_PER_MF-1:0] acc;
        logic [SA_COUNT-1:0][SW_PER_MF-1:0] snap;
        logic                               primed;
    } rx_t;

    rx_t            st_d, st_q;
    logic [SWW-1:0] pos;

    always_comb begin
        st_d = st_q;
        pos  = SWW'(SW_PER_MF - 1) - sw_sel;
        load = mf_begin & st_q.primed;

        if (slot_hit)
            st_d.acc[sa_sel][pos] = bit_in;

        if (mf_begin) begin
            if (st_q.primed)
                st_d.snap = st_q.acc;
            st_d.acc    = '0;
            st_d.primed = 1'b1;
        end

        snap = st_q.snap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/sa_tx_shadow.sv
module sa_tx_shadow #(
    parameter  int SA_COUNT  = 5,
    parameter  int SW_PER_MF = 8,
    localparam int SAW = $clog2(SA_COUNT),
    localparam int SWW = $clog2(SW_PER_MF)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [SAW-1:0]                     sa_sel,
    input  logic [SWW-1:0]                     sw_sel,
    input  logic                               mf_begin,
    input  logic [SA_COUNT-1:0][SW_PER_MF-1:0] src,
    output logic [SA_COUNT-1:0][SW_PER_MF-1:0] shadow,
    output logic                               sa_bit,
    output logic                               copy
);
    typedef struct packed {
        logic [SA_COUNT-1:0][SW_PER_MF-1:0] shd;
    } tx_t;

    tx_t            st_d, st_q;
    logic [SWW-1:0] pos;

    always_comb begin
        st_d   = st_q;
        pos    = SWW'(SW_PER_MF - 1) - sw_sel;
        copy   = mf_begin;
        // the register value of this edge goes in; a same-edge write lands after
        if (mf_begin)
            st_d.shd = src;
        shadow = st_q.shd;
        sa_bit = st_q.shd[sa_sel][pos];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/sa_reg_bank.sv
module sa_reg_bank
    import sa_pkg::*;
#(
    parameter int SA_COUNT  = 5,
    parameter int SW_PER_MF = 8,
    parameter int AW        = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [AW-1:0]                      addr,
    input  logic                               we,
    input  logic [SW_PER_MF-1:0]               wdata,
    output logic [SW_PER_MF-1:0]               rdata,
    input  logic [SA_COUNT-1:0][SW_PER_MF-1:0] rx_snap,
    input  logic                               rx_load,
    input  logic                               tx_copy,
    output logic [SA_COUNT-1:0][SW_PER_MF-1:0] xsa,
    output irq_pair_t                          stat,
    output logic                               irq_rx,
    output logic                               irq_tx
);
    typedef struct packed {
        logic [SA_COUNT-1:0][SW_PER_MF-1:0] xsa;
        irq_pair_t                          stat;
        irq_pair_t                          mask;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int k = 0; k < SA_COUNT; k++)
                if (addr == AW'(TX_BASE + k))
                    st_d.xsa[k] = wdata;
            if (addr == AW'(STAT_ADDR)) begin
                if (wdata[0]) st_d.stat.rx = 1'b0;
                if (wdata[1]) st_d.stat.tx = 1'b0;
            end
            if (addr == AW'(MASK_ADDR)) begin
                st_d.mask.rx = wdata[0];
                st_d.mask.tx = wdata[1];
            end
        end
        // a new event wins over a clear in the same cycle
        if (rx_load) st_d.stat.rx = 1'b1;
        if (tx_copy) st_d.stat.tx = 1'b1;

        rdata = '0;
        for (int k = 0; k < SA_COUNT; k++) begin
            if (addr == AW'(RX_BASE + k)) rdata = rx_snap[k];
            if (addr == AW'(TX_BASE + k)) rdata = st_q.xsa[k];
        end
        if (addr == AW'(STAT_ADDR)) rdata = SW_PER_MF'(st_q.stat);
        if (addr == AW'(MASK_ADDR)) rdata = SW_PER_MF'(st_q.mask);

        xsa    = st_q.xsa;
        stat   = st_q.stat;
        irq_rx = st_q.stat.rx & st_q.mask.rx;
        irq_tx = st_q.stat.tx & st_q.mask.tx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/sa_bit_access.sv
module sa_bit_access
    import sa_pkg::*;
#(
    parameter  int FRAME_BITS = 256,
    parameter  int MF_FRAMES  = 16,
    parameter  int SA_COUNT   = 5,
    parameter  int SA_FIRST   = 3,
    parameter  int AW         = 4,
    localparam int SW_PER_MF  = MF_FRAMES / 2,
    localparam int SAW        = $clog2(SA_COUNT),
    localparam int SWW        = $clog2(SW_PER_MF),
    localparam int SNAP_W     = SA_COUNT * SW_PER_MF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_bit_en,
    input  logic                 rx_frm_start,
    input  logic                 rx_mf_start,
    input  logic                 rx_data,
    input  logic                 tx_bit_en,
    input  logic                 tx_frm_start,
    input  logic                 tx_mf_start,
    input  logic                 tx_data_in,
    input  logic                 ts0_transparent,
    output logic                 tx_data_out,
    output logic                 tx_sa_ins,
    input  logic [AW-1:0]        reg_addr,
    input  logic                 reg_we,
    input  logic [SW_PER_MF-1:0] reg_wdata,
    output logic [SW_PER_MF-1:0] reg_rdata,
    output logic                 irq_rx,
    output logic                 irq_tx
);
    logic                               rx_hit, tx_hit;
    logic [SAW-1:0]                     rx_sa, tx_sa;
    logic [SWW-1:0]                     rx_sw, tx_sw;
    logic                               rx_mfb, tx_mfb;
    logic                               rx_load, tx_copy, tx_bit;
    logic [SA_COUNT-1:0][SW_PER_MF-1:0] rx_snap_w, xsa_w, tx_shadow_w;
    irq_pair_t                          stat_w;

    sa_slot_tracker #(
        .FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES),
        .SA_COUNT(SA_COUNT), .SA_FIRST(SA_FIRST)
    ) u_rx_trk (
        .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en),
        .frm_start(rx_frm_start), .mf_start(rx_mf_start),
        .slot_hit(rx_hit), .sa_sel(rx_sa), .sw_sel(rx_sw), .mf_begin(rx_mfb)
    );

    sa_slot_tracker #(
        .FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES),
        .SA_COUNT(SA_COUNT), .SA_FIRST(SA_FIRST)
    ) u_tx_trk (
        .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en),
        .frm_start(tx_frm_start), .mf_start(tx_mf_start),
        .slot_hit(tx_hit), .sa_sel(tx_sa), .sw_sel(tx_sw), .mf_begin(tx_mfb)
    );

    sa_rx_collect #(.SA_COUNT(SA_COUNT), .SW_PER_MF(SW_PER_MF)) u_rx (
        .clk(clk), .rst_n(rst_n), .slot_hit(rx_hit), .sa_sel(rx_sa),
        .sw_sel(rx_sw), .bit_in(rx_data), .mf_begin(rx_mfb),
        .snap(rx_snap_w), .load(rx_load)
    );

    sa_tx_shadow #(.SA_COUNT(SA_COUNT), .SW_PER_MF(SW_PER_MF)) u_tx (
        .clk(clk), .rst_n(rst_n), .sa_sel(tx_sa), .sw_sel(tx_sw),
        .mf_begin(tx_mfb), .src(xsa_w), .shadow(tx_shadow_w),
        .sa_bit(tx_bit), .copy(tx_copy)
    );

    sa_reg_bank #(.SA_COUNT(SA_COUNT), .SW_PER_MF(SW_PER_MF), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .rx_snap(rx_snap_w),
        .rx_load(rx_load), .tx_copy(tx_copy), .xsa(xsa_w), .stat(stat_w),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    always_comb begin
        tx_sa_ins   = tx_hit & ~ts0_transparent;
        tx_data_out = tx_sa_ins ? tx_bit : tx_data_in;
    end
endmodule

// File: rtl/sa_access_chk.sv
module sa_access_chk #(
    parameter int N = 40
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_bit_en,
    input logic         rx_mf_start,
    input logic         tx_bit_en,
    input logic         tx_mf_start,
    input logic         ts0_transparent,
    input logic         tx_sa_ins,
    input logic [N-1:0] rx_snap,
    input logic [N-1:0] tx_shadow,
    input logic [1:0]   stat
);
    // R1: insertion only on a real transmit bit
    a_r1_ins_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sa_ins |-> tx_bit_en);

    // R8: transparent mode blocks insertion
    a_r8_transparent_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ts0_transparent |-> !tx_sa_ins);

    // R3: receive registers move only on a receive multiframe strobe
    a_r3_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_bit_en && rx_mf_start) |=> $stable(rx_snap));

    // R6: shadow moves only on a transmit multiframe strobe
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_bit_en && tx_mf_start) |=> $stable(tx_shadow));

    // R9: status bits rise only after their event
    a_r9_rx_stat_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(rx_bit_en && rx_mf_start));

    a_r9_tx_stat_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(tx_bit_en && tx_mf_start));
endmodule

bind sa_bit_access sa_access_chk #(.N(SNAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rx_bit_en(rx_bit_en), .rx_mf_start(rx_mf_start),
    .tx_bit_en(tx_bit_en), .tx_mf_start(tx_mf_start),
    .ts0_transparent(ts0_transparent), .tx_sa_ins(tx_sa_ins),
    .rx_snap(rx_snap_w), .tx_shadow(tx_shadow_w), .stat(stat_w)
);

// File: tb/sim_sa_bit_access.sv
module sim_sa_bit_access;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, rx_bit_en, rx_frm_start, rx_mf_start, rx_data;
    logic       tx_bit_en, tx_frm_start, tx_mf_start, tx_data_in, ts0_transparent;
    logic       tx_data_out, tx_sa_ins, reg_we, irq_rx, irq_tx;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // stimulus and expected bytes, spare bit 4 in [39:32] down to spare bit 8 in [7:0]
    localparam logic [39:0] VEC [4] = '{
        40'h80_01_FF_00_A5,
        40'h3C_C3_5A_96_69,
        40'h00_00_00_00_00,
        40'hFF_7E_12_EF_01
    };

    sa_bit_access u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_bit_en(rx_bit_en), .rx_frm_start(rx_frm_start),
        .rx_mf_start(rx_mf_start), .rx_data(rx_data),
        .tx_bit_en(tx_bit_en), .tx_frm_start(tx_frm_start),
        .tx_mf_start(tx_mf_start), .tx_data_in(tx_data_in),
        .ts0_transparent(ts0_transparent), .tx_data_out(tx_data_out),
        .tx_sa_ins(tx_sa_ins), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    function automatic logic pat_bit(logic [39:0] p, int k, int f);
        return p[(4 - k) * 8 + (7 - f / 2)];
    endfunction

    function automatic logic [7:0] pat_byte(logic [39:0] p, int k);
        return p[(4 - k) * 8 +: 8];
    endfunction

    function automatic logic filler(int f, int b);
        return ((f + b) % 3) == 0;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_chk(string req, logic [3:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 chk(req, reg_rdata, exp);
    endtask

    task automatic rx_regs_chk(string req, logic [39:0] p);
        for (int k = 0; k < 5; k++)
            bus_chk(req, 4'(k), pat_byte(p, k));
    endtask

    // one receive multiframe; frame 0 bit 0 is skipped when the previous close supplied it
    task automatic rx_mf(logic [39:0] p, bit skip_first, bit gaps);
        for (int f = 0; f < 16; f++) begin
            for (int b = 0; b < 8; b++) begin
                logic slot, d;
                if (skip_first && f == 0 && b == 0) continue;
                slot = (f % 2 == 1) && (b >= 3);
                d = slot ? pat_bit(p, b - 3, f) : filler(f, b);
                if (gaps && b == 4) begin
                    @(negedge clk);
                    rx_bit_en = 1'b0; rx_frm_start = 1'b1;
                    rx_mf_start = 1'b1; rx_data = ~d;
                end
                @(negedge clk);
                rx_bit_en = 1'b1; rx_frm_start = (b == 0);
                rx_mf_start = (f == 0 && b == 0); rx_data = d;
            end
        end
    endtask

    task automatic rx_close;
        @(negedge clk);
        rx_bit_en = 1'b1; rx_frm_start = 1'b1; rx_mf_start = 1'b1; rx_data = 1'b0;
        @(negedge clk);
        rx_bit_en = 1'b0; rx_frm_start = 1'b0; rx_mf_start = 1'b0;
    endtask

    task automatic tx_mf(string req, logic [39:0] exp, bit transp, bit wr, logic [7:0] wv);
        for (int f = 0; f < 16; f++) begin
            for (int b = 0; b < 8; b++) begin
                logic slot, e_ins, e_out;
                @(negedge clk);
                tx_bit_en = 1'b1; tx_frm_start = (b == 0);
                tx_mf_start = (f == 0 && b == 0); tx_data_in = filler(f, b);
                ts0_transparent = transp;
                if (wr && f == 0 && b == 0) begin
                    reg_addr = 4'h8; reg_wdata = wv; reg_we = 1'b1;
                end else begin
                    reg_we = 1'b0;
                end
                #1;
                slot  = (f % 2 == 1) && (b >= 3);
                e_ins = slot && !transp;
                e_out = e_ins ? pat_bit(exp, b - 3, f) : filler(f, b);
                chk({req, " insert flag"}, {7'd0, tx_sa_ins}, {7'd0, e_ins});
                chk({req, " tx bit"}, {7'd0, tx_data_out}, {7'd0, e_out});
            end
        end
        @(negedge clk);
        tx_bit_en = 1'b0; tx_frm_start = 1'b0; tx_mf_start = 1'b0;
        reg_we = 1'b0; ts0_transparent = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        rx_bit_en = 0; rx_frm_start = 0; rx_mf_start = 0; rx_data = 0;
        tx_bit_en = 0; tx_frm_start = 0; tx_mf_start = 0; tx_data_in = 0;
        ts0_transparent = 0; reg_addr = 0; reg_we = 0; reg_wdata = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        for (int k = 0; k < 5; k++) begin
            bus_chk("R10 rx reset", 4'(k), 8'h00);
            bus_chk("R10 tx reset", 4'(8 + k), 8'h00);
        end
        bus_chk("R10 stat reset", 4'hE, 8'h00);
        bus_chk("R10 mask reset", 4'hF, 8'h00);
        chk("R10 irq reset", {6'd0, irq_tx, irq_rx}, 8'h00);

        // R3 first strobe only aligns
        rx_close;
        bus_chk("R3 no load on align", 4'hE, 8'h00);
        rx_regs_chk("R3 regs after align", 40'h0);

        // table walk: R1, R2, R4 (odd rows have gaps)
        for (int i = 0; i < 4; i++) begin
            bus_wr(4'hE, 8'h03);
            rx_mf(VEC[i], 1'b1, (i % 2) == 1);
            rx_close;
            rx_regs_chk((i % 2) ? "R4 R2 rx gap load" : "R1 R2 rx load", VEC[i]);
            bus_chk("R9 rx stat set", 4'hE, 8'h01);
        end

        // R3 hold during a partial multiframe
        bus_wr(4'hE, 8'h03);
        rx_mf(VEC[0], 1'b1, 1'b0);
        rx_regs_chk("R3 hold", VEC[3]);
        bus_chk("R3 no stat mid frame", 4'hE, 8'h00);

        // R10 mask, R9 selective clear
        bus_wr(4'hF, 8'h03);
        bus_chk("R10 mask readback", 4'hF, 8'h03);
        rx_close;
        rx_regs_chk("R3 load after hold", VEC[0]);
        @(negedge clk);
        chk("R10 irq_rx on", {7'd0, irq_rx}, 8'h01);
        bus_wr(4'hE, 8'h02);
        bus_chk("R9 wrong bit keeps", 4'hE, 8'h01);
        bus_wr(4'hE, 8'h01);
        bus_chk("R9 w1c clears", 4'hE, 8'h00);
        chk("R10 irq_rx off", {7'd0, irq_rx}, 8'h00);

        // transmit table walk: R5, R9
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 5; k++) bus_wr(4'(8 + k), pat_byte(VEC[i], k));
            for (int k = 0; k < 5; k++) bus_chk("R5 tx readback", 4'(8 + k), pat_byte(VEC[i], k));
            bus_wr(4'hE, 8'h03);
            tx_mf("R5", VEC[i], 1'b0, 1'b0, 8'h00);
            bus_chk("R9 tx stat set", 4'hE, 8'h02);
            chk("R10 irq_tx on", {7'd0, irq_tx}, 8'h01);
        end

        // R6 repeat without writes
        tx_mf("R6", VEC[3], 1'b0, 1'b0, 8'h00);

        // R7 write in copy cycle
        tx_mf("R7 same cycle", VEC[3], 1'b0, 1'b1, 8'h5A);
        bus_chk("R7 reg took write", 4'h8, 8'h5A);
        tx_mf("R7 next frame", {8'h5A, VEC[3][31:0]}, 1'b0, 1'b0, 8'h00);

        // R8 transparent
        tx_mf("R8", {8'h5A, VEC[3][31:0]}, 1'b1, 1'b0, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule